// File: doc/BRIEF.md
# Flash Controller with Page Erase

This block fronts a small word-organised NOR-style storage array and a separate array of user-configuration words. Software talks to it through a 32-bit register port. That port carries a two-bit configuration register, a status word that always reports ready, three erase commands and a window onto the user-configuration words. A second port programs storage words. Programming follows NOR rules: a bit can go from 1 to 0 but never back. Only an erase returns bits to 1. A third port reads storage words back with one cycle of latency.

Every erase finishes in the same clock edge that accepts it. A page erase takes a byte address, drops the offset inside the page and checks the result against the array size before it clears anything. Erase-all clears the storage array and the user words. Erase-user clears only the user words. Programming is gated by the write-enable bit of the configuration register. Page erase and erase-all are gated by the erase-enable bit. Erase-user is not gated. Any access that is refused or undefined raises a one-cycle error pulse.

Top module: `flash_page_ctrl`

## Requirements
- R1: A permitted program write to storage word `prog_addr[..:2]` stores the bitwise AND of the word's current value and `prog_data`, so no bit ever changes from 0 to 1 through programming.
- R2: A program write has no effect and raises `err` when configuration bit 0 (write enable) is clear or when `prog_addr` is not below the storage size in bytes.
- R3: A write to register byte offset 0x008 or 0x00C (both act the same) is a page erase. The written value is rounded down to a multiple of `PAGE_BYTES`. If configuration bit 1 (erase enable) is set and the rounded value is at most storage size minus `PAGE_BYTES`, every word of that page becomes 0xFFFFFFFF. Otherwise nothing changes and `err` is raised.
- R4: A write of value 1 to register offset 0x010 is erase-all. With erase enable set, it sets every storage word and every user word to 0xFFFFFFFF. With erase enable clear, nothing changes and `err` is raised. Any other value has no effect and no error.
- R5: A write of value 1 to register offset 0x014 sets every user word to 0xFFFFFFFF, whatever the erase-enable bit holds. Any other value has no effect.
- R6: Register offset 0x004 is the configuration register. A write keeps bits 1:0 (bit 0 write enable, bit 1 erase enable). A read returns those bits with bits 31:2 as zero.
- R7: Register offset 0x000 always reads 1 (ready). A read of an offset that is not readable returns 0 and raises `err`. A write to an offset that is not writable (including 0x000) raises `err` and changes nothing. Register address bits 1:0 are ignored.
- R8: After reset, the configuration register is 0, all user words read 0xFFFFFFFF, `reg_rdata`, `rd_data` and `err` are 0, and storage contents are unchanged.
- R9: User word i sits at register byte offset 0x100 + 4*i. A write replaces it and a read returns it.
- R10: A storage read returns the addressed word on `rd_data` one cycle after `rd_en`, and gives the value from before any program write in the same cycle. An address that is not below the storage size returns 0 and raises `err`.
- R11: When a program write and an erase that covers the same word fall in the same cycle, the word ends as 0xFFFFFFFF.
- R12: `err` goes high in the cycle after an offending access and stays high for one cycle only, unless the next access also offends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| prog_en | input | 1 | Storage program strobe |
| prog_addr | input | 32 | Storage byte address to program |
| prog_data | input | 32 | Program data (ANDed into the word) |
| rd_en | input | 1 | Storage read strobe |
| rd_addr | input | 32 | Storage byte address to read |
| rd_data | output | 32 | Storage read data, one cycle after `rd_en` |
| err | output | 1 | One-cycle pulse for a refused or undefined access |

## Verification
The bench builds the block with `PAGE_BYTES` = 64, `STORE_BYTES` = 512 and `USER_WORDS` = 8. This gives eight pages of sixteen words, so the last-page boundary, addresses just past the array, unaligned page-erase values and a full readback of every word all stay within a short run. The random phase picks page-erase values up to one page past the end of the array, so the range check is hit from both sides many times. A small user area means erase-user and erase-all are easy to confirm word by word.

// File: rtl/flash_ctrl_pkg.sv
`timescale 1ns/1ps
package flash_ctrl_pkg;
  localparam int REG_AW = 12;
  localparam int DW     = 32;

  // Word index (byte offset / 4) of each register
  localparam logic [REG_AW-3:0] W_READY     = 10'd0;
  localparam logic [REG_AW-3:0] W_CONFIG    = 10'd1;
  localparam logic [REG_AW-3:0] W_ERASE_PGA = 10'd2;
  localparam logic [REG_AW-3:0] W_ERASE_PGB = 10'd3;
  localparam logic [REG_AW-3:0] W_ERASE_ALL = 10'd4;
  localparam logic [REG_AW-3:0] W_ERASE_USR = 10'd5;
  localparam int                USER_BASE_W = 64;   // byte 0x100

  localparam logic [DW-1:0] ERASE_KEY = 32'd1;

  typedef struct packed {
    logic een;  // bit 1
    logic wen;  // bit 0
  } cfg_t;
endpackage

// File: rtl/flash_user_area.sv
`timescale 1ns/1ps
module flash_user_area #(
  parameter int USER_WORDS = 64,
  parameter int UIW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [UIW-1:0] idx,
  input  logic [31:0]   wdata,
  input  logic          erase,
  output logic [31:0]   rd_word
);
  logic [31:0] mem [USER_WORDS];

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      for (int i = 0; i < USER_WORDS; i++) mem[i] <= '1;
    end else if (wr) begin
      mem[idx] <= wdata;
    end
  end

  assign rd_word = mem[idx];

  p_user_erase_r5: assert property (@(posedge clk) disable iff (rst)
    erase |=> (mem[0] == '1) && (mem[USER_WORDS-1] == '1));
endmodule

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store #(
  parameter int PAGE_BYTES  = 1024,
  parameter int STORE_BYTES = 4096,
  parameter int PIW         = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wen,
  input  logic           prog_en,
  input  logic [31:0]    prog_addr,
  input  logic [31:0]    prog_data,
  input  logic           rd_en,
  input  logic [31:0]    rd_addr,
  input  logic           pg_go,
  input  logic [PIW-1:0] pg_idx,
  input  logic           all_go,
  output logic [31:0]    rd_data,
  output logic           st_err
);
  localparam int WORDS = STORE_BYTES / 4;
  localparam int PW    = PAGE_BYTES / 4;
  localparam int PAGES = STORE_BYTES / PAGE_BYTES;
  localparam int WAW   = $clog2(WORDS);

  logic [31:0] mem [WORDS];
  logic [PAGES-1:0] page_hit;
  logic [WAW-1:0] prog_idx, rd_idx;
  logic prog_in, rd_in, prog_ok;
  logic unused_bits;

  assign prog_idx = prog_addr[WAW+1:2];
  assign rd_idx   = rd_addr[WAW+1:2];
  assign prog_in  = prog_addr < 32'(STORE_BYTES);
  assign rd_in    = rd_addr < 32'(STORE_BYTES);
  assign prog_ok  = prog_en && wen && prog_in;
  assign unused_bits = ^{prog_addr[1:0], rd_addr[1:0]};

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign page_hit[p] = all_go || (pg_go && (pg_idx == PIW'(p)));
  end

  // Erase has priority over a program write in the same cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (page_hit[i / PW]) mem[i] <= '1;
      else if (prog_ok && (prog_idx == WAW'(i))) mem[i] <= mem[i] & prog_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_in ? mem[rd_idx] : '0;
  end

  assign st_err = (prog_en && !(wen && prog_in)) || (rd_en && !rd_in);

  p_clear_only_r1: assert property (@(posedge clk) disable iff (rst)
    (prog_ok && !(|page_hit)) |=>
      ((mem[$past(prog_idx)] & ~$past(mem[prog_idx])) == '0));
  p_blocked_prog_r2: assert property (@(posedge clk) disable iff (rst)
    (prog_en && !wen && !(|page_hit)) |=>
      (mem[$past(prog_idx)] == $past(mem[prog_idx])));
  p_erase_all_r4: assert property (@(posedge clk) disable iff (rst)
    all_go |=> (mem[0] == '1) && (mem[WORDS-1] == '1));
  p_rd_range_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_in) |=> (rd_data == '0));
endmodule

// File: rtl/flash_cmd_regs.sv
`timescale 1ns/1ps
module flash_cmd_regs
  import flash_ctrl_pkg::*;
#(
  parameter int PAGE_BYTES  = 1024,
  parameter int STORE_BYTES = 4096,
  parameter int USER_WORDS  = 64,
  parameter int PIW         = 2,
  parameter int UIW         = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [31:0]       user_word,
  output logic [31:0]       reg_rdata,
  output cfg_t              cfg,
  output logic              pg_go,
  output logic [PIW-1:0]    pg_idx,
  output logic              all_go,
  output logic              usr_erase,
  output logic              usr_wr,
  output logic [UIW-1:0]    usr_idx,
  output logic              cmd_err
);
  localparam int PBW = $clog2(PAGE_BYTES);

  logic [REG_AW-3:0] widx, uoff;
  logic in_user, is_pg, is_all, is_usr, is_cfg, keyed;
  logic [31:0] aligned, rd_val;
  logic pg_in, wr_known, rd_known, wr_err, rd_err;
  logic unused_bits;

  assign widx    = reg_addr[REG_AW-1:2];
  assign unused_bits = ^reg_addr[1:0];
  assign in_user = (widx >= 10'(USER_BASE_W)) && (widx < 10'(USER_BASE_W + USER_WORDS));
  assign uoff    = widx - 10'(USER_BASE_W);
  assign usr_idx = uoff[UIW-1:0];
  assign is_pg   = (widx == W_ERASE_PGA) || (widx == W_ERASE_PGB);
  assign is_all  = widx == W_ERASE_ALL;
  assign is_usr  = widx == W_ERASE_USR;
  assign is_cfg  = widx == W_CONFIG;
  assign keyed   = reg_wdata == ERASE_KEY;

  assign aligned = reg_wdata & ~(32'(PAGE_BYTES) - 32'd1);
  assign pg_in   = aligned <= 32'(STORE_BYTES - PAGE_BYTES);
  assign pg_idx  = aligned[PBW +: PIW];

  assign pg_go     = reg_wr && is_pg && cfg.een && pg_in;
  assign all_go    = reg_wr && is_all && keyed && cfg.een;
  assign usr_erase = reg_wr && is_usr && keyed;
  assign usr_wr    = reg_wr && in_user;

  assign wr_known = is_pg || is_all || is_usr || is_cfg || in_user;
  assign rd_known = (widx == W_READY) || is_cfg || in_user;
  assign wr_err   = reg_wr && (!wr_known || (is_pg && !(cfg.een && pg_in)) ||
                               (is_all && keyed && !cfg.een));
  assign rd_err   = reg_rd && !rd_known;
  assign cmd_err  = wr_err || rd_err;

  always_comb begin
    rd_val = '0;
    if (widx == W_READY) rd_val = 32'd1;
    else if (is_cfg)     rd_val = {30'd0, cfg.een, cfg.wen};
    else if (in_user)    rd_val = user_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && is_cfg) cfg <= '{een: reg_wdata[1], wen: reg_wdata[0]};
      if (reg_rd) reg_rdata <= rd_val;
    end
  end

  p_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && widx == W_READY) |=> (reg_rdata == 32'd1));
  p_undef_read_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !rd_known) |=> (reg_rdata == '0));
  p_cfg_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && is_cfg) |=> (reg_rdata[31:2] == '0));
endmodule

// File: rtl/flash_page_ctrl.sv
`timescale 1ns/1ps
module flash_page_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int PAGE_BYTES  = 1024,
  parameter int STORE_BYTES = 4096,
  parameter int USER_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              prog_en,
  input  logic [31:0]       prog_addr,
  input  logic [31:0]       prog_data,
  input  logic              rd_en,
  input  logic [31:0]       rd_addr,
  output logic [31:0]       rd_data,
  output logic              err
);
  localparam int PAGES = STORE_BYTES / PAGE_BYTES;
  localparam int PIW   = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int UIW   = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1;

  cfg_t cfg;
  logic pg_go, all_go, usr_erase, usr_wr, cmd_err, st_err;
  logic [PIW-1:0] pg_idx;
  logic [UIW-1:0] usr_idx;
  logic [31:0] user_word;

  flash_cmd_regs #(
    .PAGE_BYTES(PAGE_BYTES), .STORE_BYTES(STORE_BYTES),
    .USER_WORDS(USER_WORDS), .PIW(PIW), .UIW(UIW)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .user_word(user_word),
    .reg_rdata(reg_rdata), .cfg(cfg), .pg_go(pg_go), .pg_idx(pg_idx),
    .all_go(all_go), .usr_erase(usr_erase), .usr_wr(usr_wr),
    .usr_idx(usr_idx), .cmd_err(cmd_err)
  );

  flash_user_area #(.USER_WORDS(USER_WORDS), .UIW(UIW)) u_user (
    .clk(clk), .rst(rst), .wr(usr_wr), .idx(usr_idx), .wdata(reg_wdata),
    .erase(usr_erase || all_go), .rd_word(user_word)
  );

  flash_store #(
    .PAGE_BYTES(PAGE_BYTES), .STORE_BYTES(STORE_BYTES), .PIW(PIW)
  ) u_store (
    .clk(clk), .rst(rst), .wen(cfg.wen), .prog_en(prog_en),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .pg_go(pg_go), .pg_idx(pg_idx), .all_go(all_go),
    .rd_data(rd_data), .st_err(st_err)
  );

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= cmd_err || st_err;
  end

  p_err_blocked_prog_r2: assert property (@(posedge clk) disable iff (rst)
    (prog_en && !cfg.wen) |=> err);
  p_err_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !reg_rd && !prog_en && !rd_en) |=> !err);
endmodule

// File: tb/flash_page_ctrl_bench.sv
`timescale 1ns/1ps
module flash_page_ctrl_bench;
  localparam int PB = 64;
  localparam int SB = 512;
  localparam int UW = 8;
  localparam int NW = SB / 4;
  localparam int PW = PB / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, prog_en = 0, rd_en = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, prog_addr = '0, prog_data = '0, rd_addr = '0;
  logic [31:0] reg_rdata, rd_data;
  logic err;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_st  [NW];
  logic [31:0] m_usr [UW];
  logic m_wen = 0, m_een = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_page_ctrl #(.PAGE_BYTES(PB), .STORE_BYTES(SB), .USER_WORDS(UW)) u_flash_page_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_en(prog_en),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .err(err)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; prog_en = 0; rd_en = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void model_erase_all_user();
    for (int i = 0; i < UW; i++) m_usr[i] = '1;
  endfunction

  // Expected effect of a register write, returns expected err
  function automatic logic model_reg_wr(logic [11:0] a, logic [31:0] d);
    int w = int'(a >> 2);
    logic [31:0] al;
    if (w == 1) begin
      m_wen = d[0]; m_een = d[1]; return 1'b0;
    end else if (w == 2 || w == 3) begin
      al = d & ~(32'(PB) - 1);
      if (!m_een || al > 32'(SB - PB)) return 1'b1;
      for (int i = 0; i < PW; i++) m_st[int'(al >> 2) + i] = '1;
      return 1'b0;
    end else if (w == 4) begin
      if (d != 1) return 1'b0;
      if (!m_een) return 1'b1;
      for (int i = 0; i < NW; i++) m_st[i] = '1;
      model_erase_all_user();
      return 1'b0;
    end else if (w == 5) begin
      if (d == 1) model_erase_all_user();
      return 1'b0;
    end else if (w >= 64 && w < 64 + UW) begin
      m_usr[w - 64] = d; return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] model_reg_rd(logic [11:0] a);
    int w = int'(a >> 2);
    if (w == 0) return 32'd1;
    if (w == 1) return {30'd0, m_een, m_wen};
    if (w >= 64 && w < 64 + UW) return m_usr[w - 64];
    return '0;
  endfunction

  function automatic logic reg_rd_known(logic [11:0] a);
    int w = int'(a >> 2);
    return (w == 0) || (w == 1) || (w >= 64 && w < 64 + UW);
  endfunction

  task automatic do_reg_wr(string req, logic [11:0] a, logic [31:0] d);
    logic e;
    e = model_reg_wr(a, d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(); idle();
    check(req, "reg write err", {31'd0, err}, {31'd0, e});
  endtask

  task automatic do_reg_rd(string req, logic [11:0] a);
    logic [31:0] exp = model_reg_rd(a);
    logic e = !reg_rd_known(a);
    reg_rd = 1; reg_addr = a;
    cyc(); idle();
    check(req, "reg read data", reg_rdata, exp);
    check(req, "reg read err", {31'd0, err}, {31'd0, e});
  endtask

  task automatic do_prog(string req, logic [31:0] a, logic [31:0] d);
    logic e = 1'b1;
    if (m_wen && a < SB) begin
      m_st[a >> 2] = m_st[a >> 2] & d; e = 1'b0;
    end
    prog_en = 1; prog_addr = a; prog_data = d;
    cyc(); idle();
    check(req, "program err", {31'd0, err}, {31'd0, e});
  endtask

  task automatic do_rd(string req, logic [31:0] a);
    logic [31:0] exp = (a < SB) ? m_st[a >> 2] : '0;
    logic e = !(a < SB);
    rd_en = 1; rd_addr = a;
    cyc(); idle();
    check(req, "storage read data", rd_data, exp);
    check(req, "storage read err", {31'd0, err}, {31'd0, e});
  endtask

  task automatic do_reset();
    rst = 1; idle();
    cyc(); cyc();
    rst = 0;
    m_wen = 0; m_een = 0;
    model_erase_all_user();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, d;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R8 reset state
    check("R8", "err after reset", {31'd0, err}, 32'd0);
    check("R8", "reg_rdata after reset", reg_rdata, 32'd0);
    check("R8", "rd_data after reset", rd_data, 32'd0);
    do_reg_rd("R8", 12'h004);
    do_reg_rd("R8", 12'h10C);
    // R7 ready and undefined offsets
    do_reg_rd("R7", 12'h000);
    do_reg_rd("R7", 12'h002);
    do_reg_rd("R7", 12'h018);
    do_reg_rd("R7", 12'h008);
    do_reg_wr("R7", 12'h000, 32'h5);
    do_reg_wr("R7", 12'h0F0, 32'h5);
    // R12 err back to low after an idle cycle
    cyc();
    check("R12", "err single pulse", {31'd0, err}, 32'd0);
    // R6 config masking
    do_reg_wr("R6", 12'h004, 32'hFFFF_FFFF);
    do_reg_rd("R6", 12'h004);
    do_reg_wr("R6", 12'h004, 32'h0000_0000);
    do_reg_rd("R6", 12'h004);
    // R4 erase-all gating and key
    do_reg_wr("R4", 12'h010, 32'd1);
    do_reg_wr("R6", 12'h004, 32'd2);
    do_reg_wr("R4", 12'h010, 32'd5);
    do_reg_wr("R4", 12'h010, 32'd1);
    do_rd("R4", 32'd0);
    do_rd("R4", 32'(SB - 4));
    // R2 program blocked
    do_prog("R2", 32'h10, 32'h0);
    do_rd("R2", 32'h10);
    do_reg_wr("R6", 12'h004, 32'd3);
    do_prog("R2", 32'(SB), 32'h0);
    do_prog("R2", 32'hFFFF_FFF0, 32'h0);
    // R1 NOR AND
    do_prog("R1", 32'h10, 32'hF0F0_00FF);
    do_rd("R1", 32'h10);
    do_prog("R1", 32'h11, 32'h0FFF_FFF0);
    do_rd("R1", 32'h10);
    do_prog("R1", 32'h10, 32'hFFFF_FFFF);
    do_rd("R1", 32'h10);
    // R10 read in the same cycle as a program write returns old value
    prog_en = 1; prog_addr = 32'h10; prog_data = 32'h0;
    rd_en = 1; rd_addr = 32'h10;
    cyc(); idle();
    check("R10", "read beside program", rd_data, m_st[4]);
    m_st[4] = '0;
    do_rd("R10", 32'h10);
    do_rd("R10", 32'(SB));
    // R3 page erase
    do_prog("R3", 32'h44, 32'h1234_0000);
    do_prog("R3", 32'h80, 32'h0000_5678);
    do_prog("R3", 32'h3C, 32'h0);
    do_reg_wr("R3", 12'h00C, 32'h47);
    do_rd("R3", 32'h44);
    do_rd("R3", 32'h80);
    do_rd("R3", 32'h3C);
    do_prog("R3", 32'(SB - 4), 32'h0);
    do_reg_wr("R3", 12'h008, 32'(SB - PB + 3));
    do_rd("R3", 32'(SB - 4));
    do_reg_wr("R3", 12'h008, 32'(SB));
    do_reg_wr("R6", 12'h004, 32'd1);
    do_reg_wr("R3", 12'h008, 32'h80);
    do_rd("R3", 32'h80);
    // R9 user words
    do_reg_wr("R9", 12'h108, 32'h0000_1234);
    do_reg_wr("R9", 12'h11C, 32'hCAFE_0001);
    do_reg_rd("R9", 12'h108);
    do_reg_rd("R9", 12'h11C);
    // R5 erase-user ignores erase enable
    do_reg_wr("R5", 12'h014, 32'd2);
    do_reg_rd("R5", 12'h108);
    do_reg_wr("R5", 12'h014, 32'd1);
    do_reg_rd("R5", 12'h108);
    do_reg_rd("R5", 12'h11C);
    // R4 erase-all also clears user words
    do_reg_wr("R9", 12'h100, 32'h0);
    do_reg_wr("R6", 12'h004, 32'd3);
    do_reg_wr("R4", 12'h010, 32'd1);
    do_reg_rd("R4", 12'h100);
    do_rd("R4", 32'h10);
    // R11 erase wins over program in the same cycle
    m_st[65] = '1;
    prog_en = 1; prog_addr = 32'h104; prog_data = 32'h0;
    reg_wr = 1; reg_addr = 12'h008; reg_wdata = 32'h100;
    cyc(); idle();
    check("R11", "err on combined cycle", {31'd0, err}, 32'd0);
    do_rd("R11", 32'h104);
    // R8 storage kept across reset
    do_prog("R8", 32'h20, 32'h0BAD_F00D);
    do_reg_wr("R9", 12'h104, 32'h0);
    do_reset();
    do_rd("R8", 32'h20);
    do_reg_rd("R8", 12'h104);
    do_reg_rd("R8", 12'h004);
    // Random phase
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: begin
          a = 32'($urandom_range(0, SB + 32)) & ~32'd3;
          a = a | 32'($urandom_range(0, 3));
          d = $urandom() | $urandom();
          do_prog("R1", a, d);
        end
        3: do_reg_wr("R6", 12'h004, $urandom());
        4: do_reg_wr("R3", ($urandom_range(0, 1) != 0) ? 12'h008 : 12'h00C,
                     32'($urandom_range(0, SB + PB)));
        5, 6: do_rd("R10", 32'($urandom_range(0, SB + 16)) & ~32'd3);
        7: do_reg_wr("R9", 12'(256 + 4 * $urandom_range(0, UW - 1)), $urandom());
        8: do_reg_rd("R9", 12'(256 + 4 * $urandom_range(0, UW)));
        default: do_reg_wr("R5", 12'h014, 32'($urandom_range(0, 2)));
      endcase
    end
    for (int i = 0; i < NW; i++) do_rd("R1", 32'(4 * i));
    for (int i = 0; i < UW; i++) do_reg_rd("R9", 12'(256 + 4 * i));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule